// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block turns one request for a target-side register access into the series of scans that a boundary-scan engine must perform. A request names the register through a select code, says whether it is a read or a write, and gives the data width and the write data. The block first loads the instruction register with the select code. It then sends a data-register scan that carries a two-bit operation code. Next it polls a busy flag with single-bit data scans until the flag clears. For a read, one last data scan collects the value, and the busy bit is stripped from the bottom of that capture. Completion is signalled with a one-cycle `done` pulse, together with `err` and `rdata`.

The scan engine is outside this block. It is reached through a request/response port. `scan_valid`/`scan_ready` hand over one scan, given as its kind (instruction or data), its length and its shift-in bits, which are shifted LSB first. `scan_done` returns the captured bits in `scan_tdo`, where bit i is the bit captured during shift i. Only one scan is outstanding at a time.

The controller is a ten-state machine:
- `ST_IDLE` goes to `ST_IR_REQ` when a request is accepted.
- `ST_IR_REQ` goes to `ST_IR_WAIT` on `scan_ready`. `ST_IR_WAIT` goes to `ST_OP_REQ` on `scan_done`.
- `ST_OP_REQ` goes to `ST_OP_WAIT` on `scan_ready`. `ST_OP_WAIT` goes to `ST_POLL_REQ` on `scan_done`.
- `ST_POLL_REQ` goes to `ST_POLL_WAIT` on `scan_ready`. `ST_POLL_WAIT` has three exits on `scan_done`:
  - back to `ST_POLL_REQ` while the flag is busy and tries remain;
  - to `ST_DONE` when the flag is busy on the last try (error);
  - when the flag is clear: to `ST_DONE` for a write, or to `ST_RD_REQ` for a read.
- `ST_RD_REQ` goes to `ST_RD_WAIT` on `scan_ready`. `ST_RD_WAIT` goes to `ST_DONE` on `scan_done`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `ireg_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_valid` has no effect while `req_ready` is low: no scan is issued for it.
- R2: The first scan of every request is an instruction scan (`scan_is_ir`=1) of exactly IR_LEN bits, with `scan_tdi` equal to the zero-extended select code. Each request issues exactly one instruction scan.
- R3: For a write, the second scan is a data scan of width+2 bits. Bits [width-1:0] carry the write data, and bits width and width+1 are both 1 (the write opcode, binary 11).
- R4: For a read, the second scan is a data scan of 2 bits with value 2 (binary 10, the read opcode).
- R5: After the opcode scan, the block issues 1-bit data scans shifting 0 and stops when the captured bit 0 is 0. With B busy replies, B+1 poll scans are issued.
- R6: The poll gives up after max(`poll_limit`,1) busy replies in a row. No further scan is issued, `done` pulses with `err`=1, and `rdata` is 0.
- R7: For a read, after the poll clears, one data scan of width+1 bits shifting 0 is issued. `rdata` equals captured bits [width:1], and the bits at and above the width are 0.
- R8: `done` is a one-cycle pulse ending each request. `err` is 0 when polling succeeded, and `rdata` is 0 after a write.
- R9: A scan request holds `scan_valid`, `scan_is_ir`, `scan_len` and `scan_tdi` stable until `scan_ready`. The next scan is not requested before `scan_done` of the previous one.
- R10: During reset `req_ready`=1, and `done`, `err`, `scan_valid` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | IR_LEN | Register select code loaded into the instruction register |
| req_width | input | $clog2(MAX_DW+1) | Data width, 1..MAX_DW |
| req_wdata | input | MAX_DW | Write data |
| poll_limit | input | POLL_W | Maximum busy replies tolerated (0 acts as 1) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached; valid with done |
| rdata | output | MAX_DW | Read result; valid with done |
| scan_valid | output | 1 | Scan request to the engine |
| scan_ready | input | 1 | Engine takes the scan request |
| scan_is_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| scan_len | output | $clog2(SCAN_W+1) | Scan length in bits |
| scan_tdi | output | SCAN_W | Bits shifted in, LSB first |
| scan_done | input | 1 | Scan finished, scan_tdo valid |
| scan_tdo | input | SCAN_W | Captured bits, bit i from shift i |

## Verification
The assertions take for granted that the engine raises `scan_done` only for a scan it has accepted. They also assume `req_width` lies between 1 and MAX_DW whenever a request is taken. The bench's engine model enforces both: it answers each accepted scan exactly once, after a fixed latency. It also stalls `scan_ready` on alternate opportunities, so the hold rule is exercised under backpressure. Every vector and directed request in the bench uses a width within 1..MAX_DW. The model's register file and busy countdown are driven only from the scans it sees, so read-backs depend on what earlier writes actually shifted.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IR_REQ,
        ST_IR_WAIT,
        ST_OP_REQ,
        ST_OP_WAIT,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SCAN_IR,
        SCAN_OP,
        SCAN_POLL,
        SCAN_RD
    } scan_kind_t;

endpackage

// File: rtl/ireg_fsm.sv
module ireg_fsm
    import ireg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    input  logic       scan_ready,
    input  logic       scan_done,
    input  logic       busy_bit,
    input  logic       last_try,
    output seq_state_t state
);

    seq_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start)      state_nx = ST_IR_REQ;
            ST_IR_REQ:    if (scan_ready) state_nx = ST_IR_WAIT;
            ST_IR_WAIT:   if (scan_done)  state_nx = ST_OP_REQ;
            ST_OP_REQ:    if (scan_ready) state_nx = ST_OP_WAIT;
            ST_OP_WAIT:   if (scan_done)  state_nx = ST_POLL_REQ;
            ST_POLL_REQ:  if (scan_ready) state_nx = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (scan_done) begin
                    if (!busy_bit) begin
                        state_nx = is_write ? ST_DONE : ST_RD_REQ;
                    end else if (last_try) begin
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_POLL_REQ;
                    end
                end
            end
            ST_RD_REQ:    if (scan_ready) state_nx = ST_RD_WAIT;
            ST_RD_WAIT:   if (scan_done)  state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ireg_poll_ctr.sv
module ireg_poll_ctr #(
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [POLL_W-1:0] limit,
    output logic              last_try
);

    logic [POLL_W-1:0] tries;
    logic [POLL_W:0]   tries_next;
    logic [POLL_W:0]   eff_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (clear) begin
            tries <= '0;
        end else if (step && !(&tries)) begin
            tries <= tries + 1'b1;
        end
    end

    always_comb begin
        tries_next = {1'b0, tries} + 1'b1;
        eff_limit  = (limit == '0) ? {{POLL_W{1'b0}}, 1'b1} : {1'b0, limit};
        last_try   = (tries_next >= eff_limit);
    end

endmodule

// File: rtl/ireg_frame.sv
module ireg_frame
    import ireg_pkg::*;
#(
    parameter int IR_LEN = 16,
    parameter int MAX_DW = 16,
    parameter int SCAN_W = 18,
    parameter int DW_W   = 5,
    parameter int LEN_W  = 5
) (
    input  scan_kind_t        kind,
    input  logic              is_write,
    input  logic [IR_LEN-1:0] sel,
    input  logic [DW_W-1:0]   width,
    input  logic [MAX_DW-1:0] wdata,
    output logic              is_ir,
    output logic [LEN_W-1:0]  len,
    output logic [SCAN_W-1:0] tdi
);

    logic [SCAN_W-1:0] wpad;
    logic [SCAN_W-1:0] wframe;
    logic [LEN_W-1:0]  width_l;

    assign wpad    = SCAN_W'(wdata);
    assign width_l = LEN_W'(width);

    always_comb begin
        for (int i = 0; i < SCAN_W; i++) begin
            if (i < int'(width)) begin
                wframe[i] = wpad[i];
            end else if ((i == int'(width)) || (i == int'(width) + 1)) begin
                wframe[i] = 1'b1;
            end else begin
                wframe[i] = 1'b0;
            end
        end
    end

    always_comb begin
        is_ir = 1'b0;
        len   = '0;
        tdi   = '0;
        unique case (kind)
            SCAN_IR: begin
                is_ir = 1'b1;
                len   = LEN_W'(IR_LEN);
                tdi   = SCAN_W'(sel);
            end
            SCAN_OP: begin
                if (is_write) begin
                    len = width_l + LEN_W'(2);
                    tdi = wframe;
                end else begin
                    len = LEN_W'(2);
                    tdi = SCAN_W'(2);
                end
            end
            SCAN_POLL: begin
                len = LEN_W'(1);
            end
            SCAN_RD: begin
                len = width_l + LEN_W'(1);
            end
            default: begin
                len = '0;
            end
        endcase
    end

endmodule

// File: rtl/ireg_rcap.sv
module ireg_rcap #(
    parameter int MAX_DW = 16,
    parameter int SCAN_W = 18,
    parameter int DW_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DW_W-1:0]   width,
    input  logic [SCAN_W-1:0] tdo,
    output logic [MAX_DW-1:0] rdata
);

    logic [MAX_DW-1:0] stripped;

    always_comb begin
        for (int i = 0; i < MAX_DW; i++) begin
            stripped[i] = (i < int'(width)) ? tdo[i+1] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (load) begin
            rdata <= stripped;
        end
    end

endmodule

// File: rtl/ireg_seq.sv
module ireg_seq
    import ireg_pkg::*;
#(
    parameter int IR_LEN = 16,
    parameter int MAX_DW = 16,
    parameter int POLL_W = 8,
    localparam int SCAN_W = (IR_LEN > MAX_DW + 2) ? IR_LEN : MAX_DW + 2,
    localparam int DW_W   = $clog2(MAX_DW + 1),
    localparam int LEN_W  = $clog2(SCAN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IR_LEN-1:0] req_sel,
    input  logic [DW_W-1:0]   req_width,
    input  logic [MAX_DW-1:0] req_wdata,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              done,
    output logic              err,
    output logic [MAX_DW-1:0] rdata,
    output logic              scan_valid,
    input  logic              scan_ready,
    output logic              scan_is_ir,
    output logic [LEN_W-1:0]  scan_len,
    output logic [SCAN_W-1:0] scan_tdi,
    input  logic              scan_done,
    input  logic [SCAN_W-1:0] scan_tdo
);

    seq_state_t        state;
    scan_kind_t        kind;
    logic              start;
    logic              last_try;
    logic              poll_resp;
    logic              timeout;
    logic              rd_load;

    logic              lat_write;
    logic [IR_LEN-1:0] lat_sel;
    logic [DW_W-1:0]   lat_width;
    logic [MAX_DW-1:0] lat_wdata;
    logic [POLL_W-1:0] lat_limit;

    // Request latch: one request held for the whole sequence.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_sel   <= '0;
            lat_width <= '0;
            lat_wdata <= '0;
            lat_limit <= '0;
        end else if (start) begin
            lat_write <= req_write;
            lat_sel   <= req_sel;
            lat_width <= req_width;
            lat_wdata <= req_wdata;
            lat_limit <= poll_limit;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        start      = req_ready && req_valid;
        done       = (state == ST_DONE);
        scan_valid = 1'b0;
        kind       = SCAN_IR;
        unique case (state)
            ST_IR_REQ:   begin scan_valid = 1'b1; kind = SCAN_IR;   end
            ST_OP_REQ:   begin scan_valid = 1'b1; kind = SCAN_OP;   end
            ST_POLL_REQ: begin scan_valid = 1'b1; kind = SCAN_POLL; end
            ST_RD_REQ:   begin scan_valid = 1'b1; kind = SCAN_RD;   end
            default:     begin scan_valid = 1'b0; kind = SCAN_IR;   end
        endcase
        poll_resp = (state == ST_POLL_WAIT) && scan_done;
        timeout   = poll_resp && scan_tdo[0] && last_try;
        rd_load   = (state == ST_RD_WAIT) && scan_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (start) begin
            err <= 1'b0;
        end else if (timeout) begin
            err <= 1'b1;
        end
    end

    ireg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_write   (lat_write),
        .scan_ready (scan_ready),
        .scan_done  (scan_done),
        .busy_bit   (scan_tdo[0]),
        .last_try   (last_try),
        .state      (state)
    );

    ireg_poll_ctr #(
        .POLL_W (POLL_W)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .step     (poll_resp),
        .limit    (lat_limit),
        .last_try (last_try)
    );

    ireg_frame #(
        .IR_LEN (IR_LEN),
        .MAX_DW (MAX_DW),
        .SCAN_W (SCAN_W),
        .DW_W   (DW_W),
        .LEN_W  (LEN_W)
    ) u_frame (
        .kind     (kind),
        .is_write (lat_write),
        .sel      (lat_sel),
        .width    (lat_width),
        .wdata    (lat_wdata),
        .is_ir    (scan_is_ir),
        .len      (scan_len),
        .tdi      (scan_tdi)
    );

    ireg_rcap #(
        .MAX_DW (MAX_DW),
        .SCAN_W (SCAN_W),
        .DW_W   (DW_W)
    ) u_rcap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .load  (rd_load),
        .width (lat_width),
        .tdo   (scan_tdo),
        .rdata (rdata)
    );

endmodule

// File: rtl/ireg_seq_chk.sv
module ireg_seq_chk #(
    parameter int IR_LEN = 16,
    parameter int SCAN_W = 18,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              scan_valid,
    input logic              scan_ready,
    input logic              scan_is_ir,
    input logic [LEN_W-1:0]  scan_len,
    input logic [SCAN_W-1:0] scan_tdi
);

    // R1: no scan is requested while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !scan_valid);

    // R2: instruction scans always have the instruction length
    p_ir_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_is_ir) |-> (scan_len == LEN_W'(IR_LEN)));

    // R5: single-bit scans shift a zero
    p_poll_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_is_ir && scan_len == LEN_W'(1)) |-> (scan_tdi == '0));

    // R6: the error flag only rises together with the completion pulse
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R8: completion is a single-cycle pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R9: a pending scan request holds all its fields
    p_scan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_ready) |=>
            (scan_valid && $stable(scan_is_ir) && $stable(scan_len) && $stable(scan_tdi)));

    // R9: after a handshake the request drops
    p_scan_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_ready) |=> !scan_valid);

endmodule

bind ireg_seq ireg_seq_chk #(
    .IR_LEN (IR_LEN),
    .SCAN_W (SCAN_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .err        (err),
    .scan_valid (scan_valid),
    .scan_ready (scan_ready),
    .scan_is_ir (scan_is_ir),
    .scan_len   (scan_len),
    .scan_tdi   (scan_tdi)
);

// File: tb/ireg_seq_bench.sv
module ireg_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IR_LEN = 16;
    localparam int MAX_DW = 16;
    localparam int POLL_W = 8;
    localparam int SCAN_W = 18;
    localparam int DW_W   = 5;
    localparam int LEN_W  = 5;

    typedef struct packed {
        logic        wr;
        logic [15:0] sel;
        logic [4:0]  width;
        logic [15:0] wdata;
        logic [7:0]  busy;
        logic [7:0]  limit;
        logic [15:0] exp_rdata;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h0011, 5'd8,  16'h00A5, 8'd2, 8'd5, 16'h0000, 1'b0},
        '{1'b0, 16'h0011, 5'd8,  16'h0000, 8'd1, 8'd5, 16'h00A5, 1'b0},
        '{1'b1, 16'h0022, 5'd16, 16'hBEEF, 8'd0, 8'd3, 16'h0000, 1'b0},
        '{1'b0, 16'h0022, 5'd16, 16'h0000, 8'd3, 8'd4, 16'hBEEF, 1'b0},
        '{1'b0, 16'h0022, 5'd4,  16'h0000, 8'd0, 8'd1, 16'h000F, 1'b0},
        '{1'b1, 16'h0033, 5'd1,  16'hFFFF, 8'd0, 8'd2, 16'h0000, 1'b0},
        '{1'b0, 16'h0033, 5'd1,  16'h0000, 8'd0, 8'd2, 16'h0001, 1'b0},
        '{1'b1, 16'h0044, 5'd8,  16'h003C, 8'd4, 8'd4, 16'h0000, 1'b1},
        '{1'b0, 16'h0044, 5'd8,  16'h0000, 8'd4, 8'd5, 16'h003C, 1'b0},
        '{1'b0, 16'h0011, 5'd8,  16'h0000, 8'd1, 8'd0, 16'h0000, 1'b1}
    };

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic              req_write;
    logic [IR_LEN-1:0] req_sel;
    logic [DW_W-1:0]   req_width;
    logic [MAX_DW-1:0] req_wdata;
    logic [POLL_W-1:0] poll_limit;
    logic              done;
    logic              err;
    logic [MAX_DW-1:0] rdata;
    logic              scan_valid;
    logic              scan_ready;
    logic              scan_is_ir;
    logic [LEN_W-1:0]  scan_len;
    logic [SCAN_W-1:0] scan_tdi;
    logic              scan_done;
    logic [SCAN_W-1:0] scan_tdo;

    int n_checks;
    int n_fail;

    // engine-side model state and per-request observations
    logic [15:0]       regs [16];
    logic [15:0]       tgt_ir;
    int                busy_left;
    int                busy_cfg;
    int                pend;
    logic [SCAN_W-1:0] pend_tdo;
    logic              stall;
    int                ir_cnt;
    logic [15:0]       ir_seen;
    int                op_len;
    logic [SCAN_W-1:0] op_tdi;
    int                poll_cnt;
    int                rd_len;

    ireg_seq #(
        .IR_LEN (IR_LEN),
        .MAX_DW (MAX_DW),
        .POLL_W (POLL_W)
    ) u_ireg_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_sel    (req_sel),
        .req_width  (req_width),
        .req_wdata  (req_wdata),
        .poll_limit (poll_limit),
        .done       (done),
        .err        (err),
        .rdata      (rdata),
        .scan_valid (scan_valid),
        .scan_ready (scan_ready),
        .scan_is_ir (scan_is_ir),
        .scan_len   (scan_len),
        .scan_tdi   (scan_tdi),
        .scan_done  (scan_done),
        .scan_tdo   (scan_tdo)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Scan engine with a small target model behind it.
    initial begin
        scan_ready = 1'b0;
        scan_done  = 1'b0;
        scan_tdo   = '0;
        pend       = 0;
        stall      = 1'b0;
        busy_left  = 0;
        tgt_ir     = '0;
        for (int i = 0; i < 16; i++) regs[i] = '0;
        forever begin
            @(negedge clk);
            scan_done = 1'b0;
            if (scan_ready) begin
                scan_ready = 1'b0;
                pend = 2;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    scan_done = 1'b1;
                    scan_tdo  = pend_tdo;
                end
            end else if (scan_valid && rst_n) begin
                stall = ~stall;
                if (!stall) begin
                    scan_ready = 1'b1;
                    pend_tdo   = '0;
                    if (scan_is_ir) begin
                        tgt_ir    = scan_tdi[15:0];
                        busy_left = 0;
                        ir_cnt++;
                        ir_seen   = scan_tdi[15:0];
                    end else if (scan_len == 1) begin
                        pend_tdo[0] = (busy_left > 0);
                        if (busy_left > 0) busy_left--;
                        poll_cnt++;
                    end else if (scan_len == 2 && scan_tdi == 2) begin
                        op_len    = 2;
                        op_tdi    = scan_tdi;
                        busy_left = busy_cfg;
                    end else if (scan_tdi == '0) begin
                        rd_len   = int'(scan_len);
                        pend_tdo = {1'b0, regs[tgt_ir[3:0]], 1'b0}
                                   & ((SCAN_W'(1) << scan_len) - SCAN_W'(1));
                    end else begin
                        op_len = int'(scan_len);
                        op_tdi = scan_tdi;
                        regs[tgt_ir[3:0]] = 16'(scan_tdi & ((SCAN_W'(1) << (scan_len - 2)) - SCAN_W'(1)));
                        busy_left = busy_cfg;
                    end
                end
            end
        end
    end

    task automatic run_req(input vec_t v, output logic got_err, output logic [15:0] got_rd,
                           output bit timed_out);
        ir_cnt   = 0;
        ir_seen  = '0;
        op_len   = 0;
        op_tdi   = '0;
        poll_cnt = 0;
        rd_len   = 0;
        busy_cfg = int'(v.busy);
        timed_out = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.wr;
        req_sel    = v.sel;
        req_width  = v.width;
        req_wdata  = v.wdata;
        poll_limit = v.limit;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
        begin
            int t;
            t = 0;
            while (!done && t < 3000) begin
                @(negedge clk);
                t++;
            end
            if (!done) timed_out = 1'b1;
        end
        got_err = err;
        got_rd  = rdata;
    endtask

    initial begin
        logic        e;
        logic [15:0] r;
        bit          to;
        int          exp_polls;
        n_checks   = 0;
        n_fail     = 0;
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_sel    = '0;
        req_width  = '0;
        req_wdata  = '0;
        poll_limit = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10 req_ready in reset", req_ready, 1);
        check(done == 1'b0 && err == 1'b0, "R10 done/err in reset", {done, err}, 0);
        check(scan_valid == 1'b0, "R10 scan_valid in reset", scan_valid, 0);
        check(rdata == '0, "R10 rdata in reset", rdata, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            run_req(VEC[k], e, r, to);
            check(!to, "R8 done reached", 0, 1);
            check(ir_cnt == 1 && ir_seen == VEC[k].sel, "R2 one IR scan with select",
                  ir_seen, VEC[k].sel);
            if (VEC[k].wr) begin
                check(op_len == int'(VEC[k].width) + 2, "R3 write scan length",
                      op_len, int'(VEC[k].width) + 2);
                check(op_tdi == ((SCAN_W'(3) << VEC[k].width) |
                                 (SCAN_W'(VEC[k].wdata) & ((SCAN_W'(1) << VEC[k].width) - 1))),
                      "R3 write scan bits", op_tdi, 0);
            end else begin
                check(op_len == 2 && op_tdi == 2, "R4 read opcode scan", op_tdi, 2);
            end
            exp_polls = VEC[k].exp_err ? ((VEC[k].limit == 0) ? 1 : int'(VEC[k].limit))
                                       : int'(VEC[k].busy) + 1;
            check(poll_cnt == exp_polls, VEC[k].exp_err ? "R6 polls before giving up"
                                                        : "R5 poll count", poll_cnt, exp_polls);
            check(e == VEC[k].exp_err, VEC[k].exp_err ? "R6 err raised" : "R8 err clear",
                  e, VEC[k].exp_err);
            if (!VEC[k].wr && !VEC[k].exp_err) begin
                check(rd_len == int'(VEC[k].width) + 1, "R7 collect scan length",
                      rd_len, int'(VEC[k].width) + 1);
            end
            if (VEC[k].exp_err) begin
                check(rd_len == 0, "R6 no collect after timeout", rd_len, 0);
            end
            check(r == VEC[k].exp_rdata, VEC[k].wr ? "R8 rdata zero after write" : "R7 rdata",
                  r, VEC[k].exp_rdata);
            @(negedge clk);
            check(done == 1'b0 && req_ready == 1'b1, "R8 done is one pulse", done, 0);
        end

        // R1: request pulsed while busy is ignored
        ir_cnt   = 0;
        poll_cnt = 0;
        busy_cfg = 3;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sel = 16'h0022;
        req_width = 5'd16; poll_limit = 8'd9;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = 16'h0055;
        req_width = 5'd8; req_wdata = 16'h0077;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(rdata == 16'hBEEF, "R1 read unaffected by ignored request", rdata, 16'hBEEF);
        repeat (20) @(negedge clk);
        check(ir_cnt == 1 && ir_seen == 16'h0022, "R1 no scan for ignored request",
              ir_seen, 16'h0022);
        check(regs[5] == 16'h0000, "R1 ignored write never reached target", regs[5], 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule